// File: doc/BRIEF.md
# Asynchronous Static Memory Bank Controller

This block turns 32-bit word requests from an internal request/acknowledge bus into read and write cycles on an external asynchronous static memory bus. The external bus serves eight banks. Each bank has its own chip-select line and its own settings: data width, wait states, turnaround gap, burst-ROM timing, chip-select polarity, write protection and whether byte-lane enables are driven on reads.

A request is decoded from fixed fields of the system address. It then runs as one, two or four external beats, depending on the bank's width. Each beat holds its strobe for a programmed number of cycles. After the last beat comes a programmed idle gap, and the request is acknowledged in the first cycle of that gap. A request that cannot be served is acknowledged at once with an error flag and drives no external strobe. Such requests are writes to protected banks and addresses outside the external region.

Top module: `smc_bank_ctrl`

## Requirements
- R1: A request is external when address bits 31:29 equal 3'b010. Bits 28:26 pick the bank. Bits 25:24 and 1:0 have no effect. The first beat's `ext_addr` is `{req_addr[23:2], 2'b00}`.
- R2: A request outside the external region gets `ack` and `ack_err` high in the cycle after acceptance. It asserts no chip-select, `ext_oe` or `ext_we`. The controller is idle again one cycle later.
- R3: Each bank's chip-select is active high when its `cfg_cs_pol` bit is 1 and active low when it is 0. Only the addressed bank's line is active, and only during its beats.
- R4: Width code (2 bits per bank): 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. An 8-bit bank runs 4 beats at addresses base+0..3. A 16-bit bank runs 2 beats at base+0 and base+2. Narrow write data sits on the low lanes, lowest bytes first. Lane enables are 4'b0001, 4'b0011 and 4'b1111.
- R5: Read data is assembled little-endian from the low lanes of each narrow beat and returned on `rdata` with `ack`.
- R6: Each beat of a normal read holds `ext_oe` for read-wait+1 cycles (wait 0..31). Each write beat holds `ext_we` for write-wait+1 cycles, then one hold cycle with chip-select active and `ext_we` low.
- R7: After the last beat, turnaround+1 idle cycles follow (turnaround 0..15). `ack` is a single-cycle pulse in the first of them.
- R8: On a read from a burst-ROM bank, the first beat lasts first-wait+1 cycles and each later beat lasts next-wait+1 cycles.
- R9: A write to a protected bank is refused as in R2: error acknowledge, no `ext_we`. Reads of that bank proceed normally.
- R10: During reads `ext_lane` equals the width mask when the bank's `cfg_rd_lane` bit is 1, and 0 otherwise.
- R11: Out of reset and between requests, all chip-selects are inactive, `ext_oe`, `ext_we` and `ack` are low, and `ext_lane` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | System byte address |
| req_wdata | input | 32 | Write word |
| ack | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Refused request, valid with `ack` |
| rdata | output | 32 | Read word, valid with `ack` |
| ext_cs | output | NB | Per-bank chip-selects |
| ext_oe | output | 1 | Output enable, high active |
| ext_we | output | 1 | Write enable, high active |
| ext_lane | output | 4 | Byte-lane enables |
| ext_addr | output | IA_W | Bank-internal byte address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |
| cfg_cs_pol | input | NB | Chip-select polarity, 1 = active high |
| cfg_width | input | 2*NB | Width codes |
| cfg_burst | input | NB | Burst-ROM timing on reads |
| cfg_wprot | input | NB | Write protection |
| cfg_rd_lane | input | NB | Drive lane enables on reads |
| cfg_rd_wait | input | WAIT_W*NB | Read wait states |
| cfg_wr_wait | input | WAIT_W*NB | Write wait states |
| cfg_bst_first | input | WAIT_W*NB | Burst first-beat wait |
| cfg_bst_next | input | WAIT_W*NB | Burst later-beat wait |
| cfg_turn | input | TURN_W*NB | Turnaround cycles minus one |

## Verification
The properties assume the configuration inputs stay fixed while a request is in flight. They also assume `req_valid` and its address, data and direction stay stable from assertion until `ack` is seen. The stimulus sets every bank's configuration once, after reset. It then issues one request at a time, drops `req_valid` in the cycle `ack` is observed, and waits for the idle cycle before starting the next request. Narrow devices are modelled on the low data lanes, with deliberate garbage on the unused upper lanes, so the lane selection done during assembly is visible.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {BW8 = 2'd0, BW16 = 2'd1, BW32 = 2'd2} bus_width_e;
  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_HOLD, ST_TURN} smc_state_e;

  // index of the final beat for a width code
  function automatic logic [1:0] last_beat(input logic [1:0] w);
    case (w)
      BW8:     return 2'd3;
      BW16:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // byte offset of a beat inside the word
  function automatic logic [1:0] beat_offset(input logic [1:0] w, input logic [1:0] beat);
    case (w)
      BW8:     return beat;
      BW16:    return {beat[0], 1'b0};
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] w);
    case (w)
      BW8:     return 4'b0001;
      BW16:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // part of the write word that goes out on the low lanes in this beat
  function automatic logic [31:0] lane_out(input logic [1:0] w, input logic [1:0] beat,
                                           input logic [31:0] data);
    case (w)
      BW8:     return {24'h0, data[8*beat +: 8]};
      BW16:    return {16'h0, data[16*beat[0] +: 16]};
      default: return data;
    endcase
  endfunction

  // place the low lanes of a beat into the word under assembly
  function automatic logic [31:0] merge_in(input logic [1:0] w, input logic [1:0] beat,
                                           input logic [31:0] acc, input logic [31:0] ext);
    logic [31:0] r;
    r = acc;
    case (w)
      BW8:     r[8*beat +: 8] = ext[7:0];
      BW16:    r[16*beat[0] +: 16] = ext[15:0];
      default: r = ext;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/smc_addr_decode.sv
module smc_addr_decode #(
  parameter int AW   = 32,
  parameter int NB   = 8,
  parameter int IA_W = 24,
  localparam int BANK_BITS = $clog2(NB)
) (
  input  logic [AW-1:0]        addr,
  output logic                 hit,
  output logic [BANK_BITS-1:0] bank,
  output logic [IA_W-1:0]      base
);
  localparam int BANK_LSB = AW - 3 - BANK_BITS;

  logic unused_alias;

  assign hit  = (addr[AW-1 -: 3] == 3'b010);
  assign bank = addr[AW-4 -: BANK_BITS];
  assign base = {addr[IA_W-1:2], 2'b00};
  // mirror bits between the bank field and the bank space, plus byte offset
  assign unused_alias = ^{addr[BANK_LSB-1:IA_W], addr[1:0]};
endmodule

// File: rtl/smc_cfg_select.sv
module smc_cfg_select #(
  parameter int NB     = 8,
  parameter int WAIT_W = 5,
  parameter int TURN_W = 4,
  localparam int BANK_BITS = $clog2(NB)
) (
  input  logic [BANK_BITS-1:0] bank,
  input  logic                 write,
  input  logic                 first,
  input  logic [2*NB-1:0]      cfg_width,
  input  logic [NB-1:0]        cfg_burst,
  input  logic [NB-1:0]        cfg_wprot,
  input  logic [NB-1:0]        cfg_rd_lane,
  input  logic [WAIT_W*NB-1:0] cfg_rd_wait,
  input  logic [WAIT_W*NB-1:0] cfg_wr_wait,
  input  logic [WAIT_W*NB-1:0] cfg_bst_first,
  input  logic [WAIT_W*NB-1:0] cfg_bst_next,
  input  logic [TURN_W*NB-1:0] cfg_turn,
  output logic [1:0]           width,
  output logic                 wprot,
  output logic                 rd_lane,
  output logic [WAIT_W-1:0]    beat_wait,
  output logic [TURN_W-1:0]    turn
);
  logic [WAIT_W-1:0] rdw, wrw, bfw, bnw;

  assign width   = cfg_width[2*bank +: 2];
  assign wprot   = cfg_wprot[bank];
  assign rd_lane = cfg_rd_lane[bank];
  assign turn    = cfg_turn[TURN_W*bank +: TURN_W];
  assign rdw     = cfg_rd_wait[WAIT_W*bank +: WAIT_W];
  assign wrw     = cfg_wr_wait[WAIT_W*bank +: WAIT_W];
  assign bfw     = cfg_bst_first[WAIT_W*bank +: WAIT_W];
  assign bnw     = cfg_bst_next[WAIT_W*bank +: WAIT_W];

  always_comb begin
    if (write)                beat_wait = wrw;
    else if (!cfg_burst[bank]) beat_wait = rdw;
    else if (first)           beat_wait = bfw;
    else                      beat_wait = bnw;
  end
endmodule

// File: rtl/smc_lane_steer.sv
module smc_lane_steer #(
  parameter int IA_W = 24
) (
  input  logic [1:0]      width,
  input  logic [1:0]      beat,
  input  logic [IA_W-1:0] base,
  input  logic [31:0]     wdata,
  input  logic            active,
  input  logic            write,
  input  logic            rd_lane,
  output logic [IA_W-1:0] addr,
  output logic [31:0]     wdata_o,
  output logic [3:0]      lane
);
  import smc_pkg::*;

  assign addr    = base + IA_W'(beat_offset(width, beat));
  assign wdata_o = lane_out(width, beat, wdata);
  assign lane    = (active && (write || rd_lane)) ? lane_mask(width) : 4'b0000;
endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl #(
  parameter int NB     = 8,
  parameter int AW     = 32,
  parameter int IA_W   = 24,
  parameter int WAIT_W = 5,
  parameter int TURN_W = 4,
  localparam int BANK_BITS = $clog2(NB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 ack,
  output logic                 ack_err,
  output logic [31:0]          rdata,
  output logic [NB-1:0]        ext_cs,
  output logic                 ext_oe,
  output logic                 ext_we,
  output logic [3:0]           ext_lane,
  output logic [IA_W-1:0]      ext_addr,
  output logic [31:0]          ext_wdata,
  input  logic [31:0]          ext_rdata,
  input  logic [NB-1:0]        cfg_cs_pol,
  input  logic [2*NB-1:0]      cfg_width,
  input  logic [NB-1:0]        cfg_burst,
  input  logic [NB-1:0]        cfg_wprot,
  input  logic [NB-1:0]        cfg_rd_lane,
  input  logic [WAIT_W*NB-1:0] cfg_rd_wait,
  input  logic [WAIT_W*NB-1:0] cfg_wr_wait,
  input  logic [WAIT_W*NB-1:0] cfg_bst_first,
  input  logic [WAIT_W*NB-1:0] cfg_bst_next,
  input  logic [TURN_W*NB-1:0] cfg_turn
);
  import smc_pkg::*;

  smc_state_e          state;
  logic [BANK_BITS-1:0] bank_q;
  logic                write_q;
  logic [1:0]          width_q;
  logic [IA_W-1:0]     base_q;
  logic [31:0]         wdata_q, rbuf;
  logic [1:0]          beat_q;
  logic [WAIT_W-1:0]   wcnt;
  logic [TURN_W-1:0]   tcnt;

  logic                 dec_hit;
  logic [BANK_BITS-1:0] dec_bank;
  logic [IA_W-1:0]      dec_base;
  logic                 idle, sel_write;
  logic [BANK_BITS-1:0] sel_bank;
  logic [1:0]           sel_width;
  logic                 sel_wprot, sel_rd_lane;
  logic [WAIT_W-1:0]    sel_wait;
  logic [TURN_W-1:0]    sel_turn;

  // named events for the checker
  logic accept, reject, beat_done, last_beat_now, bus_active;
  logic [31:0] merged;
  logic [NB-1:0] cs_act;

  smc_addr_decode #(.AW(AW), .NB(NB), .IA_W(IA_W)) u_dec (
    .addr(req_addr), .hit(dec_hit), .bank(dec_bank), .base(dec_base)
  );

  assign idle      = (state == ST_IDLE);
  assign sel_bank  = idle ? dec_bank : bank_q;
  assign sel_write = idle ? req_write : write_q;

  smc_cfg_select #(.NB(NB), .WAIT_W(WAIT_W), .TURN_W(TURN_W)) u_cfg (
    .bank(sel_bank), .write(sel_write), .first(idle),
    .cfg_width(cfg_width), .cfg_burst(cfg_burst), .cfg_wprot(cfg_wprot),
    .cfg_rd_lane(cfg_rd_lane), .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
    .cfg_bst_first(cfg_bst_first), .cfg_bst_next(cfg_bst_next), .cfg_turn(cfg_turn),
    .width(sel_width), .wprot(sel_wprot), .rd_lane(sel_rd_lane),
    .beat_wait(sel_wait), .turn(sel_turn)
  );

  assign accept        = idle && req_valid;
  assign reject        = accept && (!dec_hit || (req_write && sel_wprot));
  assign beat_done     = (state == ST_STROBE) && (wcnt == '0);
  assign last_beat_now = (beat_q == last_beat(width_q));
  assign bus_active    = (state == ST_STROBE) || (state == ST_HOLD);
  assign merged        = merge_in(width_q, beat_q, rbuf, ext_rdata);

  smc_lane_steer #(.IA_W(IA_W)) u_lane (
    .width(width_q), .beat(beat_q), .base(base_q), .wdata(wdata_q),
    .active(bus_active), .write(write_q), .rd_lane(sel_rd_lane),
    .addr(ext_addr), .wdata_o(ext_wdata), .lane(ext_lane)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_cs
      assign cs_act[b] = bus_active && (bank_q == BANK_BITS'(b));
    end
  endgenerate

  assign ext_cs = ~(cs_act ^ cfg_cs_pol);
  assign ext_oe = (state == ST_STROBE) && !write_q;
  assign ext_we = (state == ST_STROBE) && write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bank_q  <= '0;
      write_q <= 1'b0;
      width_q <= BW32;
      base_q  <= '0;
      wdata_q <= '0;
      rbuf    <= '0;
      beat_q  <= '0;
      wcnt    <= '0;
      tcnt    <= '0;
      ack     <= 1'b0;
      ack_err <= 1'b0;
      rdata   <= '0;
    end else begin
      ack     <= 1'b0;
      ack_err <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (reject) begin
            ack     <= 1'b1;
            ack_err <= 1'b1;
            tcnt    <= '0;
            state   <= ST_TURN;
          end else begin
            bank_q  <= dec_bank;
            write_q <= req_write;
            width_q <= sel_width;
            base_q  <= dec_base;
            wdata_q <= req_wdata;
            rbuf    <= '0;
            beat_q  <= '0;
            wcnt    <= sel_wait;
            state   <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (!beat_done) begin
            wcnt <= wcnt - 1'b1;
          end else if (write_q) begin
            state <= ST_HOLD;
          end else if (last_beat_now) begin
            rdata <= merged;
            ack   <= 1'b1;
            tcnt  <= sel_turn;
            state <= ST_TURN;
          end else begin
            rbuf   <= merged;
            beat_q <= beat_q + 2'd1;
            wcnt   <= sel_wait;
          end
        end
        ST_HOLD: begin
          if (last_beat_now) begin
            ack   <= 1'b1;
            tcnt  <= sel_turn;
            state <= ST_TURN;
          end else begin
            beat_q <= beat_q + 2'd1;
            wcnt   <= sel_wait;
            state  <= ST_STROBE;
          end
        end
        default: begin
          if (tcnt == '0) state <= ST_IDLE;
          else            tcnt  <= tcnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/smc_bank_ctrl_chk.sv
module smc_bank_ctrl_chk #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] cs,
  input logic [NB-1:0] pol,
  input logic [NB-1:0] wprot,
  input logic [NB-1:0] rd_lane,
  input logic          oe,
  input logic          we,
  input logic [3:0]    lane,
  input logic          ack,
  input logic          ack_err,
  input logic          beat_done
);
  logic [NB-1:0] act;
  assign act = ~(cs ^ pol);

  a_r11_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe && we));

  a_r3_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) <= 1);

  a_r3_strobe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (oe || we) |-> $countones(act) == 1);

  a_r9_no_we_protected: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ((act & wprot) == '0));

  a_r10_read_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && ((act & rd_lane) == '0)) |-> (lane == 4'b0000));

  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r7_ack_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (act == '0 && !oe && !we));

  a_r2_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> ack);

  a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we) |-> ($countones(act) == 1 && !oe));

  a_r6_beat_end_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> (oe || we));
endmodule

bind smc_bank_ctrl smc_bank_ctrl_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(ext_cs), .pol(cfg_cs_pol), .wprot(cfg_wprot),
  .rd_lane(cfg_rd_lane), .oe(ext_oe), .we(ext_we), .lane(ext_lane),
  .ack(ack), .ack_err(ack_err), .beat_done(beat_done)
);

// File: tb/smc_bank_ctrl_tb.sv
module smc_bank_ctrl_tb;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        ack, ack_err;
  logic [31:0] rdata;
  logic [NB-1:0] ext_cs;
  logic        ext_oe, ext_we;
  logic [3:0]  ext_lane;
  logic [23:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata;

  logic [NB-1:0]   cfg_cs_pol, cfg_burst, cfg_wprot, cfg_rd_lane;
  logic [2*NB-1:0] cfg_width;
  logic [5*NB-1:0] cfg_rd_wait, cfg_wr_wait, cfg_bst_first, cfg_bst_next;
  logic [4*NB-1:0] cfg_turn;

  int bw[NB]  = '{32, 16, 8, 8, 32, 32, 16, 8};
  int rdw[NB] = '{2, 0, 1, 0, 0, 31, 0, 0};
  int wrw[NB] = '{1, 0, 2, 0, 0, 31, 0, 0};
  int trn[NB] = '{0, 3, 1, 2, 0, 15, 1, 0};
  int bfw[NB] = '{0, 0, 0, 4, 0, 0, 3, 0};
  int bnw[NB] = '{0, 0, 0, 1, 0, 0, 0, 0};
  bit pol[NB] = '{0, 1, 0, 1, 0, 1, 0, 0};
  bit bst[NB] = '{0, 0, 0, 1, 0, 0, 1, 0};
  bit wp[NB]  = '{0, 0, 0, 0, 1, 0, 0, 0};
  bit rdl[NB] = '{1, 0, 1, 1, 0, 1, 1, 0};

  int vectors = 0;
  int misses  = 0;
  int cur_width = 32;
  string cur_tag = "";

  typedef struct packed {
    logic [NB-1:0] cs;
    logic          oe;
    logic          we;
    logic [3:0]    lane;
    logic [23:0]   addr;
    logic [31:0]   wdata;
    logic          ack;
    logic          err;
    logic [31:0]   rdata;
    logic          chk_rd;
  } snap_t;

  smc_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .ack_err(ack_err),
    .rdata(rdata), .ext_cs(ext_cs), .ext_oe(ext_oe), .ext_we(ext_we),
    .ext_lane(ext_lane), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .cfg_cs_pol(cfg_cs_pol), .cfg_width(cfg_width),
    .cfg_burst(cfg_burst), .cfg_wprot(cfg_wprot), .cfg_rd_lane(cfg_rd_lane),
    .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
    .cfg_bst_first(cfg_bst_first), .cfg_bst_next(cfg_bst_next), .cfg_turn(cfg_turn)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16];
  endfunction

  // memory model: narrow devices sit on the low lanes, upper lanes carry junk
  always_comb begin
    if (cur_width == 8)       ext_rdata = {24'hDEADBE, mem_byte(ext_addr)};
    else if (cur_width == 16) ext_rdata = {16'hBEEF, mem_byte(ext_addr + 24'd1), mem_byte(ext_addr)};
    else ext_rdata = {mem_byte(ext_addr + 24'd3), mem_byte(ext_addr + 24'd2),
                      mem_byte(ext_addr + 24'd1), mem_byte(ext_addr)};
  end

  function automatic logic [NB-1:0] idle_cs();
    logic [NB-1:0] v;
    for (int b = 0; b < NB; b++) v[b] = !pol[b];
    return v;
  endfunction

  task automatic check_cycle(input snap_t e, input string tag);
    snap_t a;
    a = '0;
    a.cs    = ext_cs;
    a.oe    = ext_oe;
    a.we    = ext_we;
    a.lane  = ext_lane;
    a.addr  = (e.cs != idle_cs()) ? ext_addr : 24'h0;
    a.wdata = e.we ? ext_wdata : 32'h0;
    a.ack   = ack;
    a.err   = ack_err;
    a.rdata = e.chk_rd ? rdata : 32'h0;
    a.chk_rd = e.chk_rd;
    vectors++;
    if (a !== e) begin
      misses++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, a, e);
    end
  endtask

  task automatic check_idle(input string tag);
    snap_t e;
    e = '0;
    e.cs = idle_cs();
    check_cycle(e, tag);
  endtask

  task automatic run_req(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                         input string tag);
    snap_t q[$];
    snap_t e;
    int b;
    int nb, step, wt;
    logic [3:0] mask;
    logic [23:0] base, ak;
    logic [31:0] wdk, exp_rd;
    bit bad;
    b = int'(addr[28:26]);
    bad = (addr[31:29] != 3'b010) || (wr && wp[b]);
    cur_tag = tag;
    cur_width = bw[b];
    base = {addr[23:2], 2'b00};
    nb   = (bw[b] == 8) ? 4 : (bw[b] == 16) ? 2 : 1;
    step = 4 / nb;
    mask = (bw[b] == 8) ? 4'b0001 : (bw[b] == 16) ? 4'b0011 : 4'b1111;
    exp_rd = {mem_byte(base + 24'd3), mem_byte(base + 24'd2),
              mem_byte(base + 24'd1), mem_byte(base)};
    if (bad) begin
      e = '0;
      e.cs = idle_cs();
      e.ack = 1'b1;
      e.err = 1'b1;
      q.push_back(e);
    end else begin
      for (int k = 0; k < nb; k++) begin
        ak  = base + 24'(k * step);
        wdk = (wd >> (8 * k * step));
        if (nb == 4) wdk = {24'h0, wdk[7:0]};
        else if (nb == 2) wdk = {16'h0, wdk[15:0]};
        if (wr) wt = wrw[b];
        else if (bst[b]) wt = (k == 0) ? bfw[b] : bnw[b];
        else wt = rdw[b];
        for (int c = 0; c <= wt; c++) begin
          e = '0;
          e.cs = idle_cs();
          e.cs[b] = pol[b];
          e.oe = !wr;
          e.we = wr;
          e.lane = (wr || rdl[b]) ? mask : 4'b0000;
          e.addr = ak;
          e.wdata = wr ? wdk : 32'h0;
          q.push_back(e);
        end
        if (wr) begin
          e.we = 1'b0;
          e.wdata = 32'h0;
          q.push_back(e);
        end
      end
      for (int t = 0; t <= trn[b]; t++) begin
        e = '0;
        e.cs = idle_cs();
        if (t == 0) begin
          e.ack = 1'b1;
          if (!wr) begin
            e.chk_rd = 1'b1;
            e.rdata = exp_rd;
          end
        end
        q.push_back(e);
      end
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = wd;
    while (q.size() > 0) begin
      @(negedge clk);
      e = q.pop_front();
      check_cycle(e, tag);
      if (e.ack) req_valid = 1'b0;
    end
    @(negedge clk);
    check_idle({"R11 idle after ", tag});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL watchdog expired during %s", cur_tag);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    for (int b = 0; b < NB; b++) begin
      cfg_cs_pol[b]  = pol[b];
      cfg_burst[b]   = bst[b];
      cfg_wprot[b]   = wp[b];
      cfg_rd_lane[b] = rdl[b];
      cfg_width[2*b +: 2]     = (bw[b] == 8) ? 2'd0 : (bw[b] == 16) ? 2'd1 : 2'd2;
      cfg_rd_wait[5*b +: 5]   = 5'(rdw[b]);
      cfg_wr_wait[5*b +: 5]   = 5'(wrw[b]);
      cfg_bst_first[5*b +: 5] = 5'(bfw[b]);
      cfg_bst_next[5*b +: 5]  = 5'(bnw[b]);
      cfg_turn[4*b +: 4]      = 4'(trn[b]);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R11 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R11 after reset release");

    run_req(1'b0, 32'h4000_0010, 32'h0,         "R1 R5 R6 R7 R10 bank0 word read");
    run_req(1'b1, 32'h4000_0020, 32'hA1B2_C3D4, "R6 R7 bank0 word write");
    run_req(1'b0, 32'h4700_0126, 32'h0,         "R1 R3 R4 R5 R10 bank1 aliased read");
    run_req(1'b1, 32'h4400_0200, 32'h1122_3344, "R3 R4 bank1 halfword-split write");
    run_req(1'b0, 32'h4800_0ABC, 32'h0,         "R4 R5 bank2 byte-split read");
    run_req(1'b1, 32'h4800_0040, 32'hCAFE_F00D, "R4 R6 bank2 byte-split write");
    run_req(1'b0, 32'h4C00_1000, 32'h0,         "R8 bank3 burst byte read");
    run_req(1'b1, 32'h5000_0000, 32'h0BAD_0BAD, "R9 protected write refused");
    run_req(1'b0, 32'h5000_0044, 32'h0,         "R9 protected bank read");
    run_req(1'b0, 32'h6000_0000, 32'h0,         "R2 outside region read");
    run_req(1'b1, 32'h2000_0010, 32'h1,         "R2 outside region write");
    run_req(1'b0, 32'h5400_FFFC, 32'h0,         "R6 R7 bank5 longest read");
    run_req(1'b1, 32'h5400_0008, 32'h55AA_33CC, "R6 R7 bank5 longest write");
    run_req(1'b0, 32'h5800_0010, 32'h0,         "R8 R10 bank6 burst halfword read");
    run_req(1'b0, 32'h5C00_0004, 32'h0,         "R3 R4 R10 bank7 byte read");
    run_req(1'b1, 32'h5F00_0108, 32'h8765_4321, "R1 R4 bank7 aliased write");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule